// File: doc/BRIEF.md
# Sampled Supply Monitor Controller

This block runs an external supply-voltage comparator on a duty cycle and turns what the comparator reports into a core reset, an interrupt and a wake-up request. It runs from the slow clock. Each rising edge of `clk` is one slow-clock period. A single keyed configuration word selects how often the comparator is enabled, sets the 4-bit threshold code sent with the enable strobe, and chooses which of the three consequences a detection has.

The comparator is enabled for one slow-clock period at the end of each programmed interval, or all the time in continuous mode. Its "below threshold" answer is captured at the clock edge that closes the enable window. A detection is a captured "below" answer. Three sticky flags record detections, detections that caused a reset and detections that caused a wake-up. The flags stay set until a status read clears them. The last captured comparator answer is also shown live.

Configuration word layout (`cfg_wdata`): bits 2:0 sampling mode, bits 7:4 threshold code, bit 8 reset enable, bit 9 interrupt enable, bit 10 wake-up enable, bits 31:24 key. All other bits are ignored.

Top module: `supmon_ctrl`

## Requirements
- R1: Mode 0 and the unused codes 5, 6 and 7 keep `cmp_en` low, and `sts_below` does not change. Mode 1 holds `cmp_en` high and captures the comparator on every cycle.
- R2: Modes 2, 3 and 4 raise `cmp_en` for exactly one cycle in every 32, 256 and 2048 cycles. The first window is the last cycle of the first interval, which is 31, 255 or 2047 cycles after the write takes effect.
- R3: A write that changes the mode restarts the interval count. A keyed write that leaves the mode unchanged does not move the window.
- R4: `cmp_thresh` carries bits 7:4 of the last accepted configuration word.
- R5: `sts_below` takes the value of `cmp_below` at the clock edge that ends an enable window, and holds its value between windows.
- R6: A detection with the reset enable (bit 8) set drives `core_rst_n` low for the following cycle. With bit 8 clear, `core_rst_n` stays high.
- R7: With the interrupt enable (bit 9) set, `irq` is high whenever the detection flag is set.
- R8: A detection with the wake-up enable (bit 10) set pulses `wake_req` high for the following cycle and sets the wake flag.
- R9: `sts_detect`, `sts_reset` and `sts_wake` are sticky and are cleared by `sts_read`. An event in the same cycle as the read leaves its flag set.
- R10: A configuration write takes effect only when bits 31:24 equal 0xA5. Any other key leaves the whole configuration unchanged.
- R11: After reset the mode is 0, all flags and `sts_below` are 0, `irq` and `wake_req` are low, and `core_rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word with key |
| sts_read | input | 1 | Status read strobe; clears the sticky flags |
| cmp_below | input | 1 | Comparator result, 1 = supply below threshold |
| cmp_en | output | 1 | Comparator enable strobe |
| cmp_thresh | output | 4 | Threshold code to the comparator |
| core_rst_n | output | 1 | Active-low core reset request |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake-up request pulse |
| sts_below | output | 1 | Last captured comparator result |
| sts_detect | output | 1 | Sticky flag: any detection |
| sts_reset | output | 1 | Sticky flag: detection that caused a reset |
| sts_wake | output | 1 | Sticky flag: detection that caused a wake-up |

## Verification
The assertions check these rules on every cycle:
- A rejected key leaves the mode and threshold unchanged.
- `sts_below` moves only after an enable window.
- `core_rst_n` follows the previous cycle's gated detection exactly.
- A sampled-mode window never lasts two cycles.
- A flag set at the same time as a read survives the read.
- `irq` follows an enabled detection.

Only the bench scenarios can show the interval lengths of 32, 256 and 2048 cycles, the restart of the count when the mode changes, and the absence of a restart when the same mode is rewritten. The same holds for holding the status between windows while the comparator input changes, and for matching the flag, reset and wake behaviour against an independent model under random comparator and read traffic.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

  localparam logic [7:0] SM_KEY = 8'hA5;

  // Decoded configuration held by the block
  typedef struct packed {
    logic [2:0] mode;
    logic [3:0] thresh;
    logic       rst_en;
    logic       irq_en;
    logic       wake_en;
  } sm_cfg_t;

  // Interval length of a sampled mode; 0 means not a sampled mode
  function automatic int unsigned sm_interval(input logic [2:0] m,
                                              input int unsigned a,
                                              input int unsigned b,
                                              input int unsigned c);
    case (m)
      3'd2:    return a;
      3'd3:    return b;
      3'd4:    return c;
      default: return 0;
    endcase
  endfunction

  function automatic logic sm_is_cont(input logic [2:0] m);
    return (m == 3'd1);
  endfunction

  // Field positions of the configuration word
  function automatic sm_cfg_t sm_unpack(input logic [10:0] w);
    sm_cfg_t c;
    c.mode    = w[2:0];
    c.thresh  = w[7:4];
    c.rst_en  = w[8];
    c.irq_en  = w[9];
    c.wake_en = w[10];
    return c;
  endfunction

endpackage

// File: rtl/supmon_cfg.sv
module supmon_cfg
  import supmon_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  output sm_cfg_t     cfg_q,
  output logic        cfg_wr_ok,
  output logic        mode_chg
);
  sm_cfg_t cfg_new;
  logic    unused_bits;

  assign unused_bits = ^{cfg_wdata[23:11], cfg_wdata[3]};
  assign cfg_new     = sm_unpack(cfg_wdata[10:0]);
  assign cfg_wr_ok   = cfg_wr && (cfg_wdata[31:24] == SM_KEY);
  assign mode_chg    = cfg_wr_ok && (cfg_new.mode != cfg_q.mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= '0;
    else if (cfg_wr_ok) cfg_q <= cfg_new;
  end
endmodule

// File: rtl/supmon_sched.sv
module supmon_sched
  import supmon_pkg::*;
#(
  parameter int unsigned INTV_A = 32,
  parameter int unsigned INTV_B = 256,
  parameter int unsigned INTV_C = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       mode_chg,
  input  logic       cmp_below,
  output logic       cmp_en,
  output logic       sts_below,
  output logic       detect
);
  localparam int unsigned CW  = $clog2(INTV_C) + 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] len, cnt;
  logic          sampled, cont, win_last;

  assign len      = CW'(sm_interval(mode, INTV_A, INTV_B, INTV_C));
  assign sampled  = (len != '0);
  assign cont     = sm_is_cont(mode);
  assign win_last = sampled && (cnt == len - ONE);
  assign cmp_en   = cont || win_last;
  assign detect   = cmp_en && cmp_below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt <= '0;
    else if (mode_chg || !sampled || win_last) cnt <= '0;
    else                                       cnt <= cnt + ONE;
  end

  // Result is captured by the edge that closes the enable window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_below <= 1'b0;
    else if (cmp_en) sts_below <= cmp_below;
  end
endmodule

// File: rtl/supmon_events.sv
module supmon_events (
  input  logic clk,
  input  logic rst_n,
  input  logic detect,
  input  logic rst_en,
  input  logic irq_en,
  input  logic wake_en,
  input  logic sts_read,
  output logic core_rst_n,
  output logic irq,
  output logic wake_req,
  output logic sts_detect,
  output logic sts_reset,
  output logic sts_wake
);
  localparam int NF = 3;

  logic [NF-1:0] set_v, flg;

  assign set_v = {detect && wake_en, detect && rst_en, detect};

  for (genvar i = 0; i < NF; i++) begin : g_flag
    // Set has priority over the read clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg[i] <= 1'b0;
      else        flg[i] <= set_v[i] | (flg[i] & ~sts_read);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_rst_n <= 1'b1;
      wake_req   <= 1'b0;
    end else begin
      core_rst_n <= ~set_v[1];
      wake_req   <= set_v[2];
    end
  end

  assign sts_detect = flg[0];
  assign sts_reset  = flg[1];
  assign sts_wake   = flg[2];
  assign irq        = irq_en && flg[0];
endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
  import supmon_pkg::*;
#(
  parameter int unsigned INTV_A = 32,
  parameter int unsigned INTV_B = 256,
  parameter int unsigned INTV_C = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  input  logic        sts_read,
  input  logic        cmp_below,
  output logic        cmp_en,
  output logic [3:0]  cmp_thresh,
  output logic        core_rst_n,
  output logic        irq,
  output logic        wake_req,
  output logic        sts_below,
  output logic        sts_detect,
  output logic        sts_reset,
  output logic        sts_wake
);
  sm_cfg_t    cfg_q;
  logic       cfg_wr_ok, mode_chg, detect_evt;
  logic [2:0] cur_mode;
  logic       rst_en_w, irq_en_w, wake_en_w;

  assign cur_mode   = cfg_q.mode;
  assign rst_en_w   = cfg_q.rst_en;
  assign irq_en_w   = cfg_q.irq_en;
  assign wake_en_w  = cfg_q.wake_en;
  assign cmp_thresh = cfg_q.thresh;

  supmon_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_q(cfg_q), .cfg_wr_ok(cfg_wr_ok), .mode_chg(mode_chg)
  );

  supmon_sched #(.INTV_A(INTV_A), .INTV_B(INTV_B), .INTV_C(INTV_C)) u_sched (
    .clk(clk), .rst_n(rst_n), .mode(cur_mode), .mode_chg(mode_chg),
    .cmp_below(cmp_below), .cmp_en(cmp_en), .sts_below(sts_below),
    .detect(detect_evt)
  );

  supmon_events u_evt (
    .clk(clk), .rst_n(rst_n), .detect(detect_evt), .rst_en(rst_en_w),
    .irq_en(irq_en_w), .wake_en(wake_en_w), .sts_read(sts_read),
    .core_rst_n(core_rst_n), .irq(irq), .wake_req(wake_req),
    .sts_detect(sts_detect), .sts_reset(sts_reset), .sts_wake(sts_wake)
  );
endmodule

// File: rtl/supmon_ctrl_chk.sv
module supmon_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [31:0] cfg_wdata,
  input logic        sts_read,
  input logic        cmp_below,
  input logic        cmp_en,
  input logic [3:0]  cmp_thresh,
  input logic        core_rst_n,
  input logic        irq,
  input logic        sts_below,
  input logic        sts_detect,
  input logic [2:0]  cur_mode,
  input logic        rst_en_w,
  input logic        irq_en_w,
  input logic        cfg_wr_ok,
  input logic        mode_chg,
  input logic        detect_evt
);
  // R10
  bad_key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_wdata[31:24] != 8'hA5) |=> ($stable(cur_mode) && $stable(cmp_thresh)));

  // R5
  below_on_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_below != $past(sts_below)) |-> $past(cmp_en));

  // R6
  reset_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_n == !$past(cmp_en && cmp_below && rst_en_w));

  // R2
  single_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && cur_mode >= 3'd2 && cur_mode <= 3'd4 && !mode_chg) |=> !cmp_en);

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (detect_evt && sts_read) |=> sts_detect);

  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (detect_evt && irq_en_w && !cfg_wr_ok) |=> irq);
endmodule

bind supmon_ctrl supmon_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .sts_read(sts_read), .cmp_below(cmp_below), .cmp_en(cmp_en),
  .cmp_thresh(cmp_thresh), .core_rst_n(core_rst_n), .irq(irq),
  .sts_below(sts_below), .sts_detect(sts_detect), .cur_mode(cur_mode),
  .rst_en_w(rst_en_w), .irq_en_w(irq_en_w), .cfg_wr_ok(cfg_wr_ok),
  .mode_chg(mode_chg), .detect_evt(detect_evt)
);

// File: tb/supmon_ctrl_tb.sv
`timescale 1ns/1ps
module supmon_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n, cfg_wr, sts_read, cmp_below;
  logic [31:0] cfg_wdata;
  logic        cmp_en, core_rst_n, irq, wake_req;
  logic        sts_below, sts_detect, sts_reset, sts_wake;
  logic [3:0]  cmp_thresh;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  supmon_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .sts_read(sts_read), .cmp_below(cmp_below), .cmp_en(cmp_en),
    .cmp_thresh(cmp_thresh), .core_rst_n(core_rst_n), .irq(irq),
    .wake_req(wake_req), .sts_below(sts_below), .sts_detect(sts_detect),
    .sts_reset(sts_reset), .sts_wake(sts_wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input logic [7:0] key, input logic [2:0] m,
                                     input logic [3:0] th, input logic re,
                                     input logic ie, input logic we);
    return {key, 13'b0, we, ie, re, th, 1'b0, m};
  endfunction

  function automatic int gap_of(input logic [2:0] m);
    case (m)
      3'd2: return 32;
      3'd3: return 256;
      3'd4: return 2048;
      default: return 0;
    endcase
  endfunction

  function automatic logic [6:0] pack_out();
    return {sts_below, core_rst_n, wake_req, irq, sts_detect, sts_reset, sts_wake};
  endfunction

  // Called at a negedge, returns at the negedge after the write edge
  task automatic wr(input logic [31:0] w);
    cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd();
    sts_read = 1'b1;
    @(negedge clk);
    sts_read = 1'b0;
  endtask

  // Negedges until cmp_en is seen high
  task automatic measure(output int n, input int lim);
    n = 0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if (cmp_en) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    logic b, r, re, ie, we;
    logic d_m, r_m, w_m;
    logic [3:0] th;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; sts_read = 1'b0; cmp_below = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", pack_out(), 7'b0100000);
    chk("R11 cmp_en", cmp_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 continuous, R4 threshold
    wr(cw(8'hA5, 3'd1, 4'h9, 1'b1, 1'b0, 1'b0));
    chk("R1 continuous", cmp_en, 1);
    chk("R4", cmp_thresh, 4'h9);
    // R10 wrong key aborts
    wr(cw(8'h5A, 3'd2, 4'h3, 1'b0, 1'b0, 1'b0));
    chk("R10 mode", cmp_en, 1);
    chk("R10 thresh", cmp_thresh, 4'h9);

    // R5 R6 R9 detection with reset enabled
    cmp_below = 1'b1;
    @(negedge clk);
    chk("R6 R5 R9 R7 detect", pack_out(), 7'b1000110);
    cmp_below = 1'b0;
    @(negedge clk);
    chk("R9 sticky", pack_out(), 7'b0100110);
    rd();
    chk("R9 cleared", pack_out(), 7'b0100000);
    // R9 event in read cycle wins
    cmp_below = 1'b1; sts_read = 1'b1;
    @(negedge clk);
    sts_read = 1'b0; cmp_below = 1'b0;
    chk("R9 set wins", {sts_detect, sts_reset}, 2'b11);
    rd();
    chk("R9 clear again", {sts_detect, sts_reset}, 2'b00);

    // R6 reset disabled, R7 irq, R8 wake
    wr(cw(8'hA5, 3'd1, 4'h2, 1'b0, 1'b1, 1'b1));
    cmp_below = 1'b1;
    @(negedge clk);
    chk("R6 R7 R8 gated", pack_out(), 7'b1111101);
    cmp_below = 1'b0;
    @(negedge clk);
    chk("R8 pulse R7 level", {wake_req, irq}, 2'b01);
    rd();
    chk("R7 irq drops", irq, 0);

    // R1 disabled modes ignore the comparator
    wr(cw(8'hA5, 3'd0, 4'h2, 1'b1, 1'b1, 1'b1));
    cmp_below = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 mode0", {cmp_en, sts_below, sts_detect, core_rst_n}, 4'b0001);
    cmp_below = 1'b0;
    wr(cw(8'hA5, 3'd6, 4'h2, 1'b1, 1'b1, 1'b1));
    cmp_below = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 mode6", {cmp_en, sts_below, sts_detect, core_rst_n}, 4'b0001);
    cmp_below = 1'b0;

    // R2 intervals of each sampled mode
    for (int m = 2; m <= 4; m++) begin
      wr(cw(8'hA5, 3'(m), 4'h0, 1'b1, 1'b0, 1'b0));
      measure(n, 3000);
      chk("R2 first window", n, gap_of(3'(m)) - 1);
      measure(n, 3000);
      chk("R2 interval", n, gap_of(3'(m)));
    end

    // R5 status held between windows (mode 4 window just seen)
    wr(cw(8'hA5, 3'd2, 4'h0, 1'b1, 1'b0, 1'b0));
    measure(n, 100);
    @(negedge clk);
    cmp_below = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5 hold", {sts_below, core_rst_n}, 2'b01);
    measure(n, 100);
    @(negedge clk);
    chk("R5 R6 capture", {sts_below, core_rst_n}, 2'b10);
    cmp_below = 1'b0;
    rd();

    // R3 mode change restarts the count; same mode does not
    wr(cw(8'hA5, 3'd3, 4'h0, 1'b0, 1'b0, 1'b0));
    repeat (100) @(negedge clk);
    wr(cw(8'hA5, 3'd2, 4'h0, 1'b0, 1'b0, 1'b0));
    measure(n, 300);
    chk("R3 restart", n, 31);
    wr(cw(8'hA5, 3'd2, 4'h0, 1'b0, 1'b0, 1'b0));
    repeat (10) @(negedge clk);
    @(negedge clk);
    wr(cw(8'hA5, 3'd2, 4'h7, 1'b0, 1'b0, 1'b0));
    measure(n, 300);
    chk("R3 same mode keeps phase", n, 19);

    // Random traffic in continuous mode against a bench model
    for (int blk = 0; blk < 20; blk++) begin
      cmp_below = 1'b0;
      rd();
      th = 4'($urandom); re = 1'($urandom); ie = 1'($urandom); we = 1'($urandom);
      wr(cw(8'hA5, 3'd1, th, re, ie, we));
      chk("R4 random", cmp_thresh, th);
      d_m = 0; r_m = 0; w_m = 0;
      for (int c = 0; c < 50; c++) begin
        b = 1'($urandom); r = 1'(($urandom % 4) == 0);
        cmp_below = b; sts_read = r;
        @(negedge clk);
        d_m = b | (d_m & ~r);
        r_m = (b & re) | (r_m & ~r);
        w_m = (b & we) | (w_m & ~r);
        chk("R6 R7 R8 R9 random", pack_out(),
            {b, ~(b & re), b & we, ie & d_m, d_m, r_m, w_m});
      end
      sts_read = 1'b0;
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule